// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Unit

This unit reads an inner-level stack location out of the task state segment of the running task. A caller asks for privilege level 0, 1 or 2. The unit then looks at the base, the limit and the type of the current task register. It works out where the entry for that level sits, and checks that the whole entry lies inside the segment limit. Only after that check does it read the stack pointer and the stack selector through a single memory read port.

The unit handles two formats of task state segment. In the wide format each entry is eight bytes: a dword pointer followed by a word selector. In the narrow format each entry is four bytes: a word pointer, zero-extended to the output width, followed by a word selector.

A second kind of request returns the back-link word stored at offset 0 of the segment. That request is also guarded by a limit check. Any failed check ends the request with a fault pulse instead of a result, and no memory read is issued.

The sequencer has eight named states:

| State | Role |
|-------|------|
| IDLE | Accepts a request. |
| CHECK | Decides the fault or the first read. |
| RD_PTR | Presents the pointer read. |
| WT_PTR | Waits for the pointer data. |
| RD_SEL | Presents the selector or back-link read. |
| WT_SEL | Waits for the selector data. |
| DONE | Raises the one-cycle result pulse. |
| FAULT | Raises the one-cycle fault pulse. |

The transitions are:
- IDLE→CHECK when a request is taken.
- CHECK→FAULT when any check fails.
- CHECK→RD_PTR for a stack request that passes.
- CHECK→RD_SEL for a back-link request that passes.
- RD_PTR→WT_PTR and RD_SEL→WT_SEL on a grant.
- WT_PTR→RD_SEL and WT_SEL→DONE when data returns.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `tss_stack_fetch`

## Requirements
- R1: When the type is 4'hB (busy wide format), a stack request for level L reads a dword at base+8L+4 as the pointer and a word at base+8L+8 as the selector.
- R2: When the type is 4'h3 (busy narrow format), a stack request for level L reads a word at base+4L+2. That word is zero-extended to form the pointer. The unit then reads a word at base+4L+4 as the selector.
- R3: In the wide format, a stack request for which 8L+11 exceeds the limit ends in a fault of kind 1 (limit), and no read is issued.
- R4: In the narrow format, a stack request for which 4L+5 exceeds the limit ends in a fault of kind 1 (limit), and no read is issued.
- R5: Every fault carries the task selector with bits [1:0] cleared as its code. The kind encoding is 1 = limit, 2 = level, 3 = type.
- R6: A type that is neither 4'h3 nor 4'hB gives fault kind 3, and this kind takes priority over every other check. A stack request for level 3 with a valid type gives fault kind 2. Neither case issues a read.
- R7: A back-link request faults with kind 1 when the limit is below 4 (wide) or below 2 (narrow). Otherwise it makes one word read at the base. The result carries that word as its selector and a pointer of 0. The level input is ignored for this request.
- R8: For a stack request, the pointer read comes first. The selector read is presented only after the pointer data has returned. The one-cycle result pulse appears in the cycle after the selector data returns, and never in the same cycle as a fault pulse.
- R9: A read request holds its address and size until it is granted. The ready output is high only in the idle state, and a request presented while the unit is busy is ignored.
- R10: After reset the unit is idle: ready is high, and no read, result or fault is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit can take a request |
| req_backlink | input | 1 | 1 = back-link request, 0 = stack request |
| req_level | input | 2 | Target privilege level |
| tr_sel | input | 16 | Current task selector |
| tr_base | input | ADDR_W | Task state segment base |
| tr_limit | input | ADDR_W | Task state segment limit |
| tr_type | input | 4 | Task register descriptor type |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_dword | output | 1 | 1 = dword read, 0 = word read |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DATA_W | Read data, word reads in bits [15:0] |
| out_valid | output | 1 | Result pulse |
| out_sel | output | 16 | Stack selector or back-link word |
| out_sp | output | DATA_W | Stack pointer |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | Fault kind while fault_valid |
| fault_code | output | 16 | Fault error code while fault_valid |

## Verification
The hardest situation to reach from the ports is a limit that lands exactly on the last byte of an entry, or one byte short of it, for each level and format. With a random limit these cases almost never come up. The stimulus therefore draws the limit from a small window around each threshold, and also runs directed requests at both sides of every boundary. A second hard case is a request arriving while a read is outstanding. The stimulus keeps a changing request asserted for the whole of some transactions and checks that the result still matches the first request.

// File: rtl/stkf_pkg.sv
package stkf_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHECK  = 3'd1,
        S_RD_PTR = 3'd2,
        S_WT_PTR = 3'd3,
        S_RD_SEL = 3'd4,
        S_WT_SEL = 3'd5,
        S_DONE   = 3'd6,
        S_FAULT  = 3'd7
    } stkf_state_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_LIMIT = 2'd1,
        FK_LEVEL = 2'd2,
        FK_TYPE  = 2'd3
    } stkf_fault_e;

    localparam int          TYPE_W      = 4;
    localparam int          SEL_W       = 16;
    localparam int          LVL_W       = 2;
    localparam logic [3:0]  TYPE_NARROW = 4'h3;
    localparam logic [3:0]  TYPE_WIDE   = 4'hB;
    localparam logic [1:0]  LEVEL_BAD   = 2'd3;

endpackage

// File: rtl/stkf_check.sv
module stkf_check
    import stkf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               backlink,
    input  logic [LVL_W-1:0]   level,
    input  logic [TYPE_W-1:0]  ttype,
    input  logic [ADDR_W-1:0]  limit,
    input  logic [ADDR_W-1:0]  base,
    output stkf_fault_e        fault,
    output logic               wide,
    output logic [ADDR_W-1:0]  ptr_addr,
    output logic [ADDR_W-1:0]  sel_addr
);

    localparam int EXT_W = ADDR_W + 1;

    logic              is_wide;
    logic              is_narrow;
    logic [ADDR_W-1:0] lvl_ext;
    logic [ADDR_W-1:0] entry_off;
    logic [ADDR_W-1:0] sel_step;
    logic [EXT_W-1:0]  last_byte;
    logic [EXT_W-1:0]  needed;
    logic [EXT_W-1:0]  limit_ext;

    always_comb begin
        is_wide   = (ttype == TYPE_WIDE);
        is_narrow = (ttype == TYPE_NARROW);
        lvl_ext   = ADDR_W'(level);
        if (is_wide) begin
            entry_off = (lvl_ext << 3) + ADDR_W'(4);
            sel_step  = ADDR_W'(4);
            last_byte = EXT_W'(entry_off) + EXT_W'(7);
        end else begin
            entry_off = (lvl_ext << 2) + ADDR_W'(2);
            sel_step  = ADDR_W'(2);
            last_byte = EXT_W'(entry_off) + EXT_W'(3);
        end
        if (backlink) begin
            needed = is_wide ? EXT_W'(4) : EXT_W'(2);
        end else begin
            needed = last_byte;
        end
        limit_ext = EXT_W'(limit);
    end

    always_comb begin
        if (!is_wide && !is_narrow) begin
            fault = FK_TYPE;
        end else if (!backlink && (level == LEVEL_BAD)) begin
            fault = FK_LEVEL;
        end else if (needed > limit_ext) begin
            fault = FK_LIMIT;
        end else begin
            fault = FK_NONE;
        end
    end

    always_comb begin
        wide     = is_wide;
        ptr_addr = base + entry_off;
        sel_addr = backlink ? base : (base + entry_off + sel_step);
    end

endmodule

// File: rtl/stkf_seq.sv
module stkf_seq
    import stkf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        backlink,
    input  stkf_fault_e fault,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    output stkf_state_e state,
    output logic        req_ready,
    output logic        req_fire,
    output logic        mem_req,
    output logic        ptr_phase,
    output logic        ptr_load,
    output logic        sel_load,
    output logic        out_valid,
    output logic        fault_valid
);

    stkf_state_e state_q;
    stkf_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_CHECK;
            end
            S_CHECK: begin
                if (fault != FK_NONE) state_d = S_FAULT;
                else if (backlink)    state_d = S_RD_SEL;
                else                  state_d = S_RD_PTR;
            end
            S_RD_PTR: begin
                if (mem_gnt) state_d = S_WT_PTR;
            end
            S_WT_PTR: begin
                if (mem_rvalid) state_d = S_RD_SEL;
            end
            S_RD_SEL: begin
                if (mem_gnt) state_d = S_WT_SEL;
            end
            S_WT_SEL: begin
                if (mem_rvalid) state_d = S_DONE;
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = 1'b0;
        mem_req     = 1'b0;
        ptr_phase   = 1'b0;
        ptr_load    = 1'b0;
        sel_load    = 1'b0;
        out_valid   = 1'b0;
        fault_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_CHECK:  ;
            S_RD_PTR: begin
                mem_req   = 1'b1;
                ptr_phase = 1'b1;
            end
            S_WT_PTR: ptr_load = mem_rvalid;
            S_RD_SEL: mem_req  = 1'b1;
            S_WT_SEL: sel_load = mem_rvalid;
            S_DONE:   out_valid   = 1'b1;
            S_FAULT:  fault_valid = 1'b1;
            default:  ;
        endcase
        req_fire = req_ready && req_valid;
    end

    assign state = state_q;

endmodule

// File: rtl/stkf_capture.sv
module stkf_capture
    import stkf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ptr_load,
    input  logic              sel_load,
    input  logic              wide,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] sp,
    output logic [SEL_W-1:0]  sel
);

    logic [DATA_W-1:0] sp_in;

    generate
        if (DATA_W > SEL_W) begin : g_ext
            always_comb begin
                sp_in = wide ? rdata : {{(DATA_W-SEL_W){1'b0}}, rdata[SEL_W-1:0]};
            end
        end else begin : g_noext
            always_comb begin
                sp_in = rdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            sel <= '0;
        end else begin
            if (clear) begin
                sp  <= '0;
                sel <= '0;
            end
            if (ptr_load) sp  <= sp_in;
            if (sel_load) sel <= rdata[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/tss_stack_fetch.sv
module tss_stack_fetch
    import stkf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_backlink,
    input  logic [1:0]        req_level,
    input  logic [15:0]       tr_sel,
    input  logic [ADDR_W-1:0] tr_base,
    input  logic [ADDR_W-1:0] tr_limit,
    input  logic [3:0]        tr_type,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dword,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [15:0]       out_sel,
    output logic [DATA_W-1:0] out_sp,
    output logic              fault_valid,
    output logic [1:0]        fault_kind,
    output logic [15:0]       fault_code
);

    logic              snap_backlink;
    logic [LVL_W-1:0]  snap_level;
    logic [SEL_W-1:0]  snap_sel;
    logic [ADDR_W-1:0] snap_base;
    logic [ADDR_W-1:0] snap_limit;
    logic [TYPE_W-1:0] snap_type;

    stkf_fault_e       chk_fault;
    logic              chk_wide;
    logic [ADDR_W-1:0] chk_ptr_addr;
    logic [ADDR_W-1:0] chk_sel_addr;

    stkf_state_e       seq_state;
    logic              req_fire;
    logic              ptr_phase;
    logic              ptr_load;
    logic              sel_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_backlink <= 1'b0;
            snap_level    <= '0;
            snap_sel      <= '0;
            snap_base     <= '0;
            snap_limit    <= '0;
            snap_type     <= '0;
        end else if (req_fire) begin
            snap_backlink <= req_backlink;
            snap_level    <= req_level;
            snap_sel      <= tr_sel;
            snap_base     <= tr_base;
            snap_limit    <= tr_limit;
            snap_type     <= tr_type;
        end
    end

    stkf_check #(.ADDR_W(ADDR_W)) u_check (
        .backlink (snap_backlink),
        .level    (snap_level),
        .ttype    (snap_type),
        .limit    (snap_limit),
        .base     (snap_base),
        .fault    (chk_fault),
        .wide     (chk_wide),
        .ptr_addr (chk_ptr_addr),
        .sel_addr (chk_sel_addr)
    );

    stkf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .backlink    (snap_backlink),
        .fault       (chk_fault),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .state       (seq_state),
        .req_ready   (req_ready),
        .req_fire    (req_fire),
        .mem_req     (mem_req),
        .ptr_phase   (ptr_phase),
        .ptr_load    (ptr_load),
        .sel_load    (sel_load),
        .out_valid   (out_valid),
        .fault_valid (fault_valid)
    );

    stkf_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (req_fire),
        .ptr_load (ptr_load),
        .sel_load (sel_load),
        .wide     (chk_wide),
        .rdata    (mem_rdata),
        .sp       (out_sp),
        .sel      (out_sel)
    );

    always_comb begin
        if (mem_req) begin
            mem_addr  = ptr_phase ? chk_ptr_addr : chk_sel_addr;
            mem_dword = ptr_phase && chk_wide;
        end else begin
            mem_addr  = '0;
            mem_dword = 1'b0;
        end
        if (fault_valid) begin
            fault_kind = chk_fault;
            fault_code = {snap_sel[SEL_W-1:2], 2'b00};
        end else begin
            fault_kind = FK_NONE;
            fault_code = '0;
        end
    end

endmodule

// File: rtl/stkf_checker.sv
module stkf_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dword,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              out_valid,
    input logic              fault_valid,
    input logic [1:0]        fault_kind,
    input logic [15:0]       fault_code
);

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_dword)));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || out_valid || fault_valid) |-> !req_ready);

    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && fault_valid));

    assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_result_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_rvalid));

    assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code[1:0] == 2'b00 && fault_kind != 2'd0));

    assert_no_read_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !mem_req);

endmodule

bind tss_stack_fetch stkf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stkf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_dword   (mem_dword),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .out_valid   (out_valid),
    .fault_valid (fault_valid),
    .fault_kind  (fault_kind),
    .fault_code  (fault_code)
);

// File: tb/tss_stack_fetch_tb.sv
module tss_stack_fetch_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_backlink = 1'b0;
    logic [1:0]  req_level = '0;
    logic [15:0] tr_sel = '0;
    logic [31:0] tr_base = '0;
    logic [31:0] tr_limit = '0;
    logic [3:0]  tr_type = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_dword;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [15:0] out_sel;
    logic [31:0] out_sp;
    logic        fault_valid;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;

    int tests = 0;
    int errors = 0;
    logic [31:0] rd_addr [0:3];
    logic        rd_dw   [0:3];

    always #(CLK_PERIOD/2) clk = ~clk;

    tss_stack_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_backlink(req_backlink), .req_level(req_level), .tr_sel(tr_sel),
        .tr_base(tr_base), .tr_limit(tr_limit), .tr_type(tr_type),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_sel(out_sel), .out_sp(out_sp),
        .fault_valid(fault_valid), .fault_kind(fault_kind), .fault_code(fault_code)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h1234};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_calc(input bit bl, input logic [1:0] lvl, input logic [3:0] typ,
                               input logic [31:0] lim, input logic [31:0] base,
                               output logic [1:0] fk, output logic [31:0] sp,
                               output logic [15:0] sel, output int nrd,
                               output logic [31:0] a0, output logic [31:0] a1);
        bit w;
        longint off;
        longint need;
        w = (typ == 4'hB);
        off = w ? (longint'(lvl) * 8 + 4) : (longint'(lvl) * 4 + 2);
        need = bl ? (w ? 4 : 2) : (w ? off + 7 : off + 3);
        fk = 2'd0; sp = '0; sel = '0; nrd = 0; a0 = '0; a1 = '0;
        if (typ != 4'hB && typ != 4'h3)      fk = 2'd3;
        else if (!bl && lvl == 2'd3)         fk = 2'd2;
        else if (need > longint'(lim))       fk = 2'd1;
        else if (bl) begin
            nrd = 1; a0 = base; sel = memf(base)[15:0];
        end else begin
            nrd = 2;
            a0 = base + 32'(off);
            a1 = base + 32'(off) + (w ? 32'd4 : 32'd2);
            sp = w ? memf(a0) : {16'h0, memf(a0)[15:0]};
            sel = memf(a1)[15:0];
        end
    endtask

    task automatic run(input bit bl, input logic [1:0] lvl, input logic [3:0] typ,
                       input logic [31:0] lim, input logic [31:0] base,
                       input logic [15:0] sel, input bit noise);
        logic [1:0]  e_fk;
        logic [31:0] e_sp;
        logic [15:0] e_sel;
        int          e_n;
        logic [31:0] e_a0;
        logic [31:0] e_a1;
        int          nrd = 0;
        bit          pend = 0;
        int          dly = 0;
        logic [31:0] paddr = '0;
        int          last_rv = -10;
        int          done_at = -1;
        bit          got_ok = 0;
        bit          got_flt = 0;
        logic [1:0]  a_fk = '0;
        logic [15:0] a_code = '0;
        logic [31:0] a_sp = '0;
        logic [15:0] a_sel = '0;
        expect_calc(bl, lvl, typ, lim, base, e_fk, e_sp, e_sel, e_n, e_a0, e_a1);
        @(negedge clk);
        req_valid = 1'b1; req_backlink = bl; req_level = lvl; tr_type = typ;
        tr_limit = lim; tr_base = base; tr_sel = sel;
        @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
        if (noise) begin
            req_backlink = ~bl; req_level = lvl + 2'd1; tr_base = $urandom;
            tr_limit = $urandom; tr_sel = $urandom;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 0; c < 80; c++) begin
            if (out_valid || fault_valid) begin
                got_ok = out_valid; got_flt = fault_valid; a_fk = fault_kind;
                a_code = fault_code; a_sp = out_sp; a_sel = out_sel; done_at = c;
                break;
            end
            mem_gnt = 1'b0; mem_rvalid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rvalid = 1'b1; mem_rdata = memf(paddr); pend = 0; last_rv = c;
                end else dly--;
            end else if (mem_req && ($urandom % 3 != 0)) begin
                mem_gnt = 1'b1;
                if (nrd < 4) begin rd_addr[nrd] = mem_addr; rd_dw[nrd] = mem_dword; end
                nrd++; pend = 1; paddr = mem_addr; dly = $urandom % 3;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
        if (!got_ok && !got_flt) begin
            check(1'b0, "R8 watchdog no outcome", 64'd0, 64'd1);
            return;
        end
        check(nrd == e_n, "R8 read count", 64'(nrd), 64'(e_n));
        if (e_fk != 2'd0) begin
            check(got_flt && a_fk == e_fk, "R3 R4 R6 R7 fault kind", 64'(a_fk), 64'(e_fk));
            check(a_code == {sel[15:2], 2'b00}, "R5 fault code", 64'(a_code), 64'({sel[15:2], 2'b00}));
        end else begin
            check(got_ok, "R1 R2 R7 result expected", 64'(got_flt), 64'd0);
            check(a_sp == e_sp && a_sel == e_sel, "R1 R2 R7 R9 result value",
                  {a_sp, 16'h0, a_sel}, {e_sp, 16'h0, e_sel});
            check(done_at == last_rv + 1, "R8 result one cycle after data", 64'(done_at), 64'(last_rv + 1));
            if (nrd == e_n && e_n == 2) begin
                check(rd_addr[0] == e_a0 && rd_dw[0] == (typ == 4'hB), "R8 pointer read first",
                      {31'h0, rd_dw[0], rd_addr[0]}, {31'h0, (typ == 4'hB), e_a0});
                check(rd_addr[1] == e_a1 && rd_dw[1] == 1'b0, "R1 R2 selector read",
                      {31'h0, rd_dw[1], rd_addr[1]}, {32'h0, e_a1});
            end else if (nrd == e_n && e_n == 1) begin
                check(rd_addr[0] == e_a0 && rd_dw[0] == 1'b0, "R7 back-link read",
                      {31'h0, rd_dw[0], rd_addr[0]}, {32'h0, e_a0});
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !mem_req && !out_valid && !fault_valid, "R10 reset state",
              {60'h0, req_ready, mem_req, out_valid, fault_valid}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req && !out_valid && !fault_valid, "R10 idle after reset",
              {60'h0, req_ready, mem_req, out_valid, fault_valid}, 64'h8);
        // directed corners
        run(0, 2'd0, 4'hB, 32'h67, 32'h1000, 16'h002B, 0);  // R1
        run(0, 2'd2, 4'hB, 32'h1B, 32'hFFFF_FFF0, 16'h0013, 0); // R1 exact fit
        run(0, 2'd2, 4'hB, 32'h1A, 32'h2000, 16'h0013, 0);  // R3 one short
        run(0, 2'd1, 4'h3, 32'h2B, 32'h3000, 16'h0049, 0);  // R2
        run(0, 2'd2, 4'h3, 32'h0D, 32'h3000, 16'h0049, 0);  // R2 exact fit
        run(0, 2'd2, 4'h3, 32'h0C, 32'h3000, 16'h004A, 0);  // R4 one short
        run(0, 2'd3, 4'hB, 32'hFFFF, 32'h4000, 16'h0057, 0); // R6 level
        run(0, 2'd3, 4'h9, 32'hFFFF, 32'h4000, 16'h0057, 0); // R6 type priority
        run(1, 2'd3, 4'hB, 32'h4, 32'h5000, 16'h0063, 0);   // R7 wide ok, level ignored
        run(1, 2'd0, 4'hB, 32'h3, 32'h5000, 16'h0063, 0);   // R7 wide short
        run(1, 2'd0, 4'h3, 32'h2, 32'h5100, 16'h0063, 0);   // R7 narrow ok
        run(1, 2'd0, 4'h3, 32'h1, 32'h5100, 16'h0063, 0);   // R7 narrow short
        run(0, 2'd1, 4'hB, 32'h67, 32'h6000, 16'h0071, 1);  // R9 noise while busy
        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  t;
            logic [1:0]  l;
            logic [31:0] lim;
            bit          bl;
            int          r;
            r = $urandom % 8;
            t = (r < 3) ? 4'hB : (r < 6) ? 4'h3 : 4'($urandom);
            l = 2'($urandom);
            bl = ($urandom % 5 == 0);
            if ($urandom % 2 == 0) lim = (t == 4'hB) ? 32'(l) * 8 + 9 + ($urandom % 5)
                                                     : 32'(l) * 4 + 3 + ($urandom % 5);
            else lim = $urandom % 200;
            if (bl && ($urandom % 2 == 0)) lim = $urandom % 6;
            run(bl, l, t, lim, $urandom, 16'($urandom), ($urandom % 6 == 0));
        end
        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

endmodule